// File: doc/BRIEF.md
# Flash Write-Cycle Qualification Guard

This block stands between an asynchronous parallel memory bus and the command state machine of a NOR-flash-style device. It decides whether a bus write cycle reaches the command register. The three active-low bus strobes (chip enable, write enable and output enable) pass through synchronisers in a fast clock domain. A glitch filter then requires each change to persist for a set number of samples. A write cycle counts only when chip enable and write enable are both low and output enable is high. At the end of such a cycle the block issues one qualified write strobe together with the address and data that were on the bus at that moment.

Three more conditions block a cycle. A supply-lockout input, driven by an external low-supply detector, stops writes and holds the command logic in reset while asserted. A power-up latch discards a write edge when the strobes were already low at power-up. A cycle that is cut short by a lockout pulse is dropped as well. The block also takes a temporary-unprotect input from an external high-voltage detector. While that input is asserted, the reported sector-group protection flags read as all clear. When it drops, the flags show the stored protection again.

Top module: `flash_wr_guard`

## Requirements
- R1: A write cycle exists while the filtered chip enable and write enable are both low and the filtered output enable is high. When write enable or chip enable rises (the first of the two) with output enable still high, exactly one `wr_stb_o` pulse follows.
- R2: If output enable is low at any time during a cycle, or when the cycle ends, no strobe is produced.
- R3: A low pulse on write enable lasting fewer than `FILT_CYC` clock samples (default 5, derived from `GLITCH_PS`/`CLK_PS`) produces no strobe. A low pulse that is clearly longer is accepted.
- R4: `wr_stb_o` is high for exactly one cycle per accepted write. In that cycle `wr_addr_o`/`wr_data_o` hold the bus address and data present just before the ending strobe rose.
- R5: While `lockout_i` is high, `cmd_rst_o` is high within three cycles and no strobe is issued. A cycle during which lockout was asserted at any point produces no strobe.
- R6: After `lockout_i` falls, `cmd_rst_o` falls within three cycles and later write cycles are accepted again.
- R7: `cmd_rst_o` is high during reset and for at least the first two cycles after it, which forces the command logic back to read-array mode.
- R8: If chip enable and write enable are both low when reset is released, the next rising edge of write enable produces no strobe. A later complete cycle is accepted.
- R9: While `tmp_unprot_i` is high, `prot_o` is all zeros. Otherwise `prot_o` follows `prot_i` with a delay of one cycle, so the stored protection returns automatically when the mode ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up) |
| ce_ni | input | 1 | Bus chip enable, active low, asynchronous |
| we_ni | input | 1 | Bus write enable, active low, asynchronous |
| oe_ni | input | 1 | Bus output enable, active low, asynchronous |
| addr_i | input | AW | Bus address |
| data_i | input | DW | Bus write data |
| lockout_i | input | 1 | Supply below lockout threshold |
| tmp_unprot_i | input | 1 | Temporary-unprotect mode request |
| prot_i | input | NGRP | Stored sector-group protection flags |
| wr_stb_o | output | 1 | Qualified write strobe, one cycle |
| wr_addr_o | output | AW | Address of the qualified write |
| wr_data_o | output | DW | Data of the qualified write |
| cmd_rst_o | output | 1 | Reset to the command state machine and program/erase control |
| prot_o | output | NGRP | Effective protection flags |

## Verification
The assertions check the following on every cycle:
- the strobe lasts one cycle;
- no strobe occurs while the command reset is asserted;
- a held lockout forces the command reset;
- the reset stays asserted right after power-up;
- a held unprotect request clears the flags;
- the effective flags never show protection that the previous input did not.

Some behaviours need a preceding sequence of strobe waveforms, so only the directed scenarios can show them:
- rejection of short low pulses;
- the output-enable inhibit;
- loss of a cycle interrupted by lockout;
- the discarded first edge after power-up;
- capture of the correct address and data.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef struct packed {
    logic oe_n;
    logic we_n;
    logic ce_n;
  } bus_ctl_t;

  function automatic int unsigned filt_cycles(input int unsigned clk_ps,
                                              input int unsigned glitch_ps);
    int unsigned n;
    n = (glitch_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST;
      sync_q <= RST;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/glitch_filt.sv
module glitch_filt #(
  parameter int unsigned CYC     = 5,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic q_q;

  generate
    if (CYC <= 1) begin : g_pass
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= RST_VAL;
        else         q_q <= d_i;
      end
    end else begin : g_cnt
      localparam int unsigned CW = $clog2(CYC);
      localparam logic [CW-1:0] LAST = CW'(CYC - 1);
      logic [CW-1:0] cnt_q;

      // output flips only after CYC consecutive differing samples
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q_q   <= RST_VAL;
          cnt_q <= '0;
        end else if (d_i == q_q) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          q_q   <= d_i;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  endgenerate

  assign q_o = q_q;
endmodule

// File: rtl/wr_qual.sv
module wr_qual import flash_guard_pkg::*; #(
  parameter int unsigned AW = 21,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bus_ctl_t      ctl_s_i,
  input  bus_ctl_t      ctl_f_i,
  input  logic          lock_s_i,
  input  logic [AW-1:0] addr_s_i,
  input  logic [DW-1:0] data_s_i,
  output logic          stb_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic          act, act_q, ok_q, ok_d, pu_inh_q, end_ev, stb_d, cap_en;
  logic [AW-1:0] addr_cap_q;
  logic [DW-1:0] data_cap_q;

  assign act    = ~ctl_f_i.ce_n & ~ctl_f_i.we_n & ctl_f_i.oe_n;
  assign cap_en = ~ctl_s_i.ce_n & ~ctl_s_i.we_n & ctl_s_i.oe_n;

  // cycle stays valid only if entered cleanly and never locked out
  always_comb begin
    ok_d = 1'b0;
    if (act) ok_d = (act_q ? ok_q : 1'b1) & ~lock_s_i & ~pu_inh_q;
  end

  assign end_ev = act_q & ~act & ctl_f_i.oe_n;
  assign stb_d  = end_ev & ok_q & ~lock_s_i & ~pu_inh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b1;
      ok_q     <= 1'b0;
      pu_inh_q <= 1'b1;
      stb_o    <= 1'b0;
    end else begin
      act_q <= act;
      ok_q  <= ok_d;
      stb_o <= stb_d;
      if (ctl_f_i.ce_n | ctl_f_i.we_n) pu_inh_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_cap_q <= '0;
      data_cap_q <= '0;
      addr_o     <= '0;
      data_o     <= '0;
    end else begin
      if (cap_en) begin
        addr_cap_q <= addr_s_i;
        data_cap_q <= data_s_i;
      end
      if (stb_d) begin
        addr_o <= addr_cap_q;
        data_o <= data_cap_q;
      end
    end
  end
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard import flash_guard_pkg::*; #(
  parameter int unsigned AW        = 21,
  parameter int unsigned DW        = 8,
  parameter int unsigned NGRP      = 8,
  parameter int unsigned CLK_PS    = 1000,
  parameter int unsigned GLITCH_PS = 5000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ce_ni,
  input  logic            we_ni,
  input  logic            oe_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   data_i,
  input  logic            lockout_i,
  input  logic            tmp_unprot_i,
  input  logic [NGRP-1:0] prot_i,
  output logic            wr_stb_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [DW-1:0]   wr_data_o,
  output logic            cmd_rst_o,
  output logic [NGRP-1:0] prot_o
);
  localparam int unsigned FILT_CYC = filt_cycles(CLK_PS, GLITCH_PS);
  localparam int unsigned NCTL     = 3;
  localparam int unsigned NSYNC    = NCTL + 2;
  localparam int unsigned BW       = AW + DW;
  // {tmp, lock, oe, we, ce}: strobes start active, lockout starts asserted
  localparam logic [NSYNC-1:0] SYNC_RST = 5'b01100;
  localparam logic [NCTL-1:0]  FILT_RST = 3'b100;

  logic [NSYNC-1:0] ctl_raw, ctl_sync;
  logic [BW-1:0]    bus_sync;
  logic [NCTL-1:0]  filt_q;
  bus_ctl_t         ctl_s, ctl_f;
  logic             lock_s, tmp_s, cmd_rst_q;
  logic [NGRP-1:0]  prot_q;

  assign ctl_raw = {tmp_unprot_i, lockout_i, oe_ni, we_ni, ce_ni};

  bit_sync #(.W(NSYNC), .RST(SYNC_RST)) u_ctl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_sync)
  );

  bit_sync #(.W(BW), .RST('0)) u_bus_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({addr_i, data_i}),
    .q_o   (bus_sync)
  );

  assign ctl_s  = bus_ctl_t'(ctl_sync[NCTL-1:0]);
  assign lock_s = ctl_sync[NCTL];
  assign tmp_s  = ctl_sync[NCTL+1];

  for (genvar g = 0; g < NCTL; g++) begin : g_filt
    glitch_filt #(.CYC(FILT_CYC), .RST_VAL(FILT_RST[g])) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (ctl_sync[g]),
      .q_o   (filt_q[g])
    );
  end

  assign ctl_f = bus_ctl_t'(filt_q);

  wr_qual #(.AW(AW), .DW(DW)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctl_s_i (ctl_s),
    .ctl_f_i (ctl_f),
    .lock_s_i(lock_s),
    .addr_s_i(bus_sync[BW-1:DW]),
    .data_s_i(bus_sync[DW-1:0]),
    .stb_o   (wr_stb_o),
    .addr_o  (wr_addr_o),
    .data_o  (wr_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_rst_q <= 1'b1;
      prot_q    <= '1;
    end else begin
      cmd_rst_q <= lock_s;
      prot_q    <= tmp_s ? '0 : prot_i;
    end
  end

  assign cmd_rst_o = cmd_rst_q;
  assign prot_o    = prot_q;
endmodule

// File: rtl/flash_wr_guard_chk.sv
module flash_wr_guard_chk #(
  parameter int unsigned NGRP = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lockout_i,
  input logic            tmp_unprot_i,
  input logic [NGRP-1:0] prot_i,
  input logic            wr_stb_o,
  input logic            cmd_rst_o,
  input logic [NGRP-1:0] prot_o
);
  logic [2:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 3'd7)   age_q <= age_q + 1'b1;
  end

  AST_STB_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o); // R4

  AST_NO_STB_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rst_o |-> !wr_stb_o); // R5

  AST_LOCK_FORCES_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd3 && $past(lockout_i, 1) && $past(lockout_i, 2) && $past(lockout_i, 3))
      |-> cmd_rst_o); // R5

  AST_PWRUP_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q < 3'd2) |-> cmd_rst_o); // R7

  AST_UNPROT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd3 && $past(tmp_unprot_i, 1) && $past(tmp_unprot_i, 2) && $past(tmp_unprot_i, 3))
      |-> (prot_o == '0)); // R9

  AST_PROT_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd1) |-> ((prot_o & ~$past(prot_i)) == '0)); // R9
endmodule

bind flash_wr_guard flash_wr_guard_chk #(.NGRP(NGRP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lockout_i   (lockout_i),
  .tmp_unprot_i(tmp_unprot_i),
  .prot_i      (prot_i),
  .wr_stb_o    (wr_stb_o),
  .cmd_rst_o   (cmd_rst_o),
  .prot_o      (prot_o)
);

// File: tb/tb_flash_wr_guard.sv
module tb_flash_wr_guard;
  localparam int AW = 21, DW = 8, NGRP = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic lockout_i = 1'b0, tmp_unprot_i = 1'b0;
  logic [NGRP-1:0] prot_i = '0;
  logic wr_stb_o, cmd_rst_o;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;
  logic [NGRP-1:0] prot_o;

  int total = 0, bad = 0;
  int stb_cnt = 0;
  int stb_wide = 0;
  logic stb_prev = 1'b0;
  logic [AW-1:0] cap_addr = '0;
  logic [DW-1:0] cap_data = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_wr_guard dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni),
    .addr_i(addr_i), .data_i(data_i), .lockout_i(lockout_i),
    .tmp_unprot_i(tmp_unprot_i), .prot_i(prot_i), .wr_stb_o(wr_stb_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .cmd_rst_o(cmd_rst_o),
    .prot_o(prot_o)
  );

  always @(negedge clk) begin
    if (wr_stb_o) begin
      stb_cnt++;
      cap_addr = wr_addr_o;
      cap_data = wr_data_o;
      if (stb_prev) stb_wide++;
    end
    stb_prev = wr_stb_o;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // full write cycle; end_by_ce selects which strobe rises first
  task automatic do_write(input bit end_by_ce, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr_i = a; data_i = d; oe_ni = 1'b1; ce_ni = 1'b0;
    cyc(2);
    we_ni = 1'b0;
    cyc(12);
    if (end_by_ce) ce_ni = 1'b1; else we_ni = 1'b1;
    cyc(2);
    ce_ni = 1'b1; we_ni = 1'b1;
    cyc(4);
    addr_i = ~a; data_i = ~d;
    cyc(16);
  endtask

  task automatic do_reset(input bit strobes_low);
    @(negedge clk);
    rst_ni = 1'b0;
    ce_ni = !strobes_low; we_ni = !strobes_low; oe_ni = 1'b1;
    cyc(3);
    chk(cmd_rst_o === 1'b1, "R7 cmd_rst in reset", cmd_rst_o, 1);
    chk(wr_stb_o === 1'b0, "R7 no strobe in reset", wr_stb_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cmd_rst_o === 1'b1, "R7 cmd_rst after reset", cmd_rst_o, 1);
    cyc(20);
    chk(cmd_rst_o === 1'b0, "R7 cmd_rst released", cmd_rst_o, 0);
  endtask

  task automatic t_basic;
    int c0;
    c0 = stb_cnt;
    do_write(1'b0, 21'h1ABCD, 8'h5A);
    chk(stb_cnt == c0 + 1, "R1 WE-ended write", stb_cnt - c0, 1);
    chk(cap_addr == 21'h1ABCD, "R4 address", cap_addr, 21'h1ABCD);
    chk(cap_data == 8'h5A, "R4 data", cap_data, 8'h5A);
    c0 = stb_cnt;
    do_write(1'b1, 21'h00F0F, 8'hC3);
    chk(stb_cnt == c0 + 1, "R1 CE-ended write", stb_cnt - c0, 1);
    chk(cap_addr == 21'h00F0F && cap_data == 8'hC3, "R4 CE-ended capture", cap_data, 8'hC3);
    chk(stb_wide == 0, "R4 single-cycle strobe", stb_wide, 0);
  endtask

  task automatic t_oe_inhibit;
    int c0;
    c0 = stb_cnt;
    @(negedge clk);
    oe_ni = 1'b0; ce_ni = 1'b0;
    cyc(2); we_ni = 1'b0; cyc(12); we_ni = 1'b1; cyc(2); ce_ni = 1'b1; cyc(4);
    oe_ni = 1'b1; cyc(16);
    chk(stb_cnt == c0, "R2 OE low whole cycle", stb_cnt - c0, 0);
    c0 = stb_cnt;
    ce_ni = 1'b0; cyc(2); we_ni = 1'b0; cyc(12);
    oe_ni = 1'b0; cyc(10); we_ni = 1'b1; cyc(2); ce_ni = 1'b1; cyc(4);
    oe_ni = 1'b1; cyc(16);
    chk(stb_cnt == c0, "R2 OE falls mid-cycle", stb_cnt - c0, 0);
  endtask

  task automatic t_glitch;
    int c0;
    c0 = stb_cnt;
    @(negedge clk);
    oe_ni = 1'b1; ce_ni = 1'b0; cyc(2);
    we_ni = 1'b0; cyc(3); we_ni = 1'b1; cyc(16);
    chk(stb_cnt == c0, "R3 short WE pulse", stb_cnt - c0, 0);
    we_ni = 1'b0; cyc(10); we_ni = 1'b1; cyc(16);
    chk(stb_cnt == c0 + 1, "R3 long WE pulse", stb_cnt - c0, 1);
    ce_ni = 1'b1; cyc(10);
  endtask

  task automatic t_lockout;
    int c0;
    @(negedge clk);
    lockout_i = 1'b1; cyc(4);
    chk(cmd_rst_o === 1'b1, "R5 cmd_rst on lockout", cmd_rst_o, 1);
    c0 = stb_cnt;
    do_write(1'b0, 21'h12345, 8'h11);
    chk(stb_cnt == c0, "R5 write during lockout", stb_cnt - c0, 0);
    lockout_i = 1'b0; cyc(4);
    chk(cmd_rst_o === 1'b0, "R6 cmd_rst after lockout", cmd_rst_o, 0);
    c0 = stb_cnt;
    do_write(1'b0, 21'h0BEEF, 8'h22);
    chk(stb_cnt == c0 + 1 && cap_data == 8'h22, "R6 write resumes", stb_cnt - c0, 1);
    c0 = stb_cnt;
    ce_ni = 1'b0; cyc(2); we_ni = 1'b0; cyc(10);
    lockout_i = 1'b1; cyc(4); lockout_i = 1'b0; cyc(10);
    we_ni = 1'b1; cyc(2); ce_ni = 1'b1; cyc(16);
    chk(stb_cnt == c0, "R5 lockout inside cycle", stb_cnt - c0, 0);
  endtask

  task automatic t_powerup;
    int c0;
    do_reset(1'b1);
    c0 = stb_cnt;
    we_ni = 1'b1; cyc(16);
    chk(stb_cnt == c0, "R8 first WE edge dropped", stb_cnt - c0, 0);
    ce_ni = 1'b1; cyc(10);
    do_write(1'b0, 21'h0AAAA, 8'h77);
    chk(stb_cnt == c0 + 1 && cap_addr == 21'h0AAAA, "R8 later write accepted", stb_cnt - c0, 1);
  endtask

  task automatic t_unprot;
    @(negedge clk);
    prot_i = 8'hA5; tmp_unprot_i = 1'b0; cyc(5);
    chk(prot_o == 8'hA5, "R9 stored protection", prot_o, 8'hA5);
    tmp_unprot_i = 1'b1; cyc(5);
    chk(prot_o == 8'h00, "R9 unprotected", prot_o, 0);
    prot_i = 8'h3C; cyc(3);
    chk(prot_o == 8'h00, "R9 still unprotected", prot_o, 0);
    tmp_unprot_i = 1'b0; cyc(5);
    chk(prot_o == 8'h3C, "R9 protection restored", prot_o, 8'h3C);
  endtask

  initial begin
    do_reset(1'b0);
    t_basic();
    t_oe_inhibit();
    t_glitch();
    t_lockout();
    t_powerup();
    t_unprot();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule